// File: doc/BRIEF.md
# Masked Address/Data Break Comparator

This block watches every bus cycle that the processor core and the other bus masters issue, and compares each one against four independent break channels. Each channel holds a compare address with a per-bit ignore mask and a cycle qualifier. The qualifier restricts which cycles can hit by bus master, by fetch or data access, by read or write, and optionally by operand size. Two of the four channels, the upper two, also hold a compare data word with its own ignore mask. That data compare takes part only when the channel's data-enable bit is set.

When a channel hits, it sets a sticky flag. The interrupt line is the OR of the four flags. Software clears a flag by pulsing a one on the matching bit of the clear input. For instruction fetches, each channel chooses one of two timings. In pre-execution timing, a hold strobe goes out in the same cycle as the fetch, so the pipeline can stop that instruction before it completes. In post-execution timing, the channel records the fetch tag and sets its flag only when the core reports that tag as retired.

Top module: `brk_unit`

## Requirements
- R1: While reset is asserted, and after it is released, all four flags, the interrupt and the hold strobe are 0 until a channel hits.
- R2: An address bit whose mask bit is 1 is left out of the compare. Every unmasked bit must be equal for a hit (mask 0x7F on 0x3080 covers 0x3080..0x30FF; mask 0x6 on 0x8010 hits 0x8016 but not 0x8011).
- R3: Data compare uses the same masking rule. It applies only on the upper NUM_DCH channels (indices 2 and 3 by default), and only when qualifier bit 11 is 1. Elsewhere, data never affects a hit.
- R4: Qualifier bit 0 enables the channel. Bits [2:1] select the master: 01 means the core only (bus_cpu=1), 10 means other masters only, and 00 or 11 mean any master. Bits [4:3] select the access: 01 means fetch only, 10 means data only, and other values mean any access. Bits [6:5] select the direction: 01 means read only, 10 means write only, and other values mean either direction.
- R5: When qualifier bit 7 is 1, bus_size must equal qualifier bits [9:8]. When bit 7 is 0, operand size is ignored.
- R6: A fetch hit with qualifier bit 10 = 0 (pre-execution) drives brk_hold high in the same cycle as the bus cycle, and sets the flag at the next clock edge.
- R7: A fetch hit with bit 10 = 1 (post-execution) does not drive brk_hold and does not set the flag at fetch time. The flag is set at the edge where retire_valid arrives with retire_tag equal to the recorded fetch tag. A retire carrying any other tag has no effect.
- R8: A data-access hit sets the flag at the next clock edge, whatever the value of bit 10.
- R9: Flags are sticky. A 1 on flag_clr[i] clears only flag i. If a set and a clear of the same flag fall in one cycle, the set wins.
- R10: brk_irq is high exactly when at least one flag is set.
- R11: A disabled channel never hits. Channels hit independently, so one bus cycle can set several flags.
- R12: A post-execution channel keeps only its newest matching fetch tag. A later matching fetch replaces the earlier pending tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | AW | Cycle address |
| bus_data | input | DW | Cycle data |
| bus_cpu | input | 1 | 1 when the core is the bus master |
| bus_fetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| bus_write | input | 1 | 1 for a write cycle |
| bus_size | input | 2 | Operand size code |
| bus_tag | input | TW | Fetch tag, used in post-execution timing |
| retire_valid | input | 1 | An instruction retired this clock |
| retire_tag | input | TW | Tag of the retired instruction |
| cfg_addr | input | NCH*AW | Compare addresses, channel i at slice i |
| cfg_amask | input | NCH*AW | Address ignore masks |
| cfg_data | input | NCH*DW | Compare data |
| cfg_dmask | input | NCH*DW | Data ignore masks |
| cfg_qual | input | NCH*12 | Cycle qualifiers |
| flag_clr | input | NCH | Write-one-to-clear pulses for the flags |
| brk_hold | output | 1 | Pre-execution hit on the current fetch |
| brk_flags | output | NCH | Sticky per-channel hit flags |
| brk_irq | output | 1 | Break interrupt request |

## Verification
The bench targets the mask boundaries: the last address inside a 0x7F window and the first one outside it, and an unmasked low bit under mask 0x6. A comparator that inverted the mask, or that compared masked bits, would raise false hits there or miss real ones. It checks that the data compare stays out of the lower channels and out of any channel whose data-enable bit is clear; a design that always compared data would drop hits there. For post-execution timing, it checks that the flag stays low at fetch time and on a retire with a stale or wrong tag, and rises only on the matching retire. An early flag, or one that ignored the tag, would fail. It also checks that a set arriving in the same cycle as a clear wins, and that clearing one flag leaves the others and the interrupt intact.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int QW = 12;

  typedef struct packed {
    logic       den;     // [11] data compare enable
    logic       post;    // [10] post-execution timing for fetches
    logic [1:0] size;    // [9:8] required operand size
    logic       szchk;   // [7] operand size checked
    logic [1:0] dir;     // [6:5] 01 read, 10 write
    logic [1:0] acc;     // [4:3] 01 fetch, 10 data
    logic [1:0] master;  // [2:1] 01 core, 10 other
    logic       en;      // [0] channel enable
  } qual_t;

  function automatic logic sel_ok(input logic [1:0] sel, input logic is_a);
    case (sel)
      2'b01:   sel_ok = is_a;
      2'b10:   sel_ok = !is_a;
      default: sel_ok = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/brk_chan_match.sv
module brk_chan_match
  import brk_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter bit HAS_DATA = 1'b0
) (
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          bus_cpu,
  input  logic          bus_fetch,
  input  logic          bus_write,
  input  logic [1:0]    bus_size,
  input  logic [AW-1:0] ref_addr,
  input  logic [AW-1:0] ref_amask,
  input  logic [DW-1:0] ref_data,
  input  logic [DW-1:0] ref_dmask,
  input  qual_t         qual,
  output logic          hit,
  output logic          hit_pre,
  output logic          hit_post
);
  logic addr_ok;
  logic data_ok;
  logic type_ok;
  logic size_ok;

  always_comb begin
    addr_ok = ((bus_addr ^ ref_addr) & ~ref_amask) == '0;
  end

  generate
    if (HAS_DATA) begin : g_data
      always_comb begin
        data_ok = !qual.den || (((bus_data ^ ref_data) & ~ref_dmask) == '0);
      end
    end else begin : g_nodata
      logic unused_data;
      always_comb begin
        unused_data = ^{bus_data, ref_data, ref_dmask};
        data_ok     = 1'b1;
      end
    end
  endgenerate

  always_comb begin
    type_ok = sel_ok(qual.master, bus_cpu) &&
              sel_ok(qual.acc, bus_fetch) &&
              sel_ok(qual.dir, !bus_write);
    size_ok = !qual.szchk || (bus_size == qual.size);
    hit      = bus_valid && qual.en && addr_ok && data_ok && type_ok && size_ok;
    hit_pre  = hit && bus_fetch && !qual.post;
    hit_post = hit && bus_fetch && qual.post;
  end
endmodule

// File: rtl/brk_chan_state.sv
module brk_chan_state #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic          hit_post,
  input  logic [TW-1:0] bus_tag,
  input  logic          retire_valid,
  input  logic [TW-1:0] retire_tag,
  input  logic          clr,
  output logic          flag
);
  logic          pend_q, pend_d;
  logic [TW-1:0] ptag_q, ptag_d;
  logic          flag_d;
  logic          retire_hit;
  logic          set_now;

  always_comb begin
    retire_hit = pend_q && retire_valid && (retire_tag == ptag_q);
    set_now    = (hit && !hit_post) || retire_hit;
    flag_d     = (flag & ~clr) | set_now;
    pend_d     = pend_q && !retire_hit;
    ptag_d     = ptag_q;
    if (hit_post) begin
      pend_d = 1'b1;
      ptag_d = bus_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag   <= 1'b0;
      pend_q <= 1'b0;
      ptag_q <= '0;
    end else begin
      flag   <= flag_d;
      pend_q <= pend_d;
      if (hit_post) ptag_q <= ptag_d;
    end
  end
endmodule

// File: rtl/brk_unit.sv
module brk_unit
  import brk_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int TW      = 4,
  parameter int NCH     = 4,
  parameter int NUM_DCH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_data,
  input  logic              bus_cpu,
  input  logic              bus_fetch,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  input  logic [TW-1:0]     bus_tag,
  input  logic              retire_valid,
  input  logic [TW-1:0]     retire_tag,
  input  logic [NCH*AW-1:0] cfg_addr,
  input  logic [NCH*AW-1:0] cfg_amask,
  input  logic [NCH*DW-1:0] cfg_data,
  input  logic [NCH*DW-1:0] cfg_dmask,
  input  logic [NCH*QW-1:0] cfg_qual,
  input  logic [NCH-1:0]    flag_clr,
  output logic              brk_hold,
  output logic [NCH-1:0]    brk_flags,
  output logic              brk_irq
);
  localparam int FIRST_DCH = NCH - NUM_DCH;

  logic [1:0]     rst_sync_q;
  logic           rst_int_n;
  logic [NCH-1:0] hit_v;
  logic [NCH-1:0] pre_v;
  logic [NCH-1:0] post_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      brk_chan_match #(
        .AW(AW), .DW(DW), .HAS_DATA(i >= FIRST_DCH)
      ) u_match (
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data),
        .bus_cpu   (bus_cpu),
        .bus_fetch (bus_fetch),
        .bus_write (bus_write),
        .bus_size  (bus_size),
        .ref_addr  (cfg_addr[i*AW +: AW]),
        .ref_amask (cfg_amask[i*AW +: AW]),
        .ref_data  (cfg_data[i*DW +: DW]),
        .ref_dmask (cfg_dmask[i*DW +: DW]),
        .qual      (qual_t'(cfg_qual[i*QW +: QW])),
        .hit       (hit_v[i]),
        .hit_pre   (pre_v[i]),
        .hit_post  (post_v[i])
      );

      brk_chan_state #(.TW(TW)) u_state (
        .clk          (clk),
        .rst_n        (rst_int_n),
        .hit          (hit_v[i]),
        .hit_post     (post_v[i]),
        .bus_tag      (bus_tag),
        .retire_valid (retire_valid),
        .retire_tag   (retire_tag),
        .clr          (flag_clr[i]),
        .flag         (brk_flags[i])
      );
    end
  endgenerate

  always_comb begin
    brk_hold = rst_int_n && (|pre_v);
    brk_irq  = |brk_flags;
  end
endmodule

// File: rtl/brk_unit_chk.sv
module brk_unit_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_valid,
  input logic           bus_fetch,
  input logic           retire_valid,
  input logic [NCH-1:0] flag_clr,
  input logic           brk_hold,
  input logic [NCH-1:0] brk_flags,
  input logic           brk_irq
);
  a_r6_hold_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    brk_hold |-> (bus_valid && bus_fetch));

  a_r10_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_irq) |-> ($past(bus_valid) || $past(retire_valid)));

  a_r10_irq_tracks_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flags != '0) |-> brk_irq);

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_flags[i] && !flag_clr[i]) |=> brk_flags[i]);

      a_r9_fall_by_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(brk_flags[i]) |-> $past(flag_clr[i]));
    end
  endgenerate
endmodule

bind brk_unit brk_unit_chk #(.NCH(NCH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_valid    (bus_valid),
  .bus_fetch    (bus_fetch),
  .retire_valid (retire_valid),
  .flag_clr     (flag_clr),
  .brk_hold     (brk_hold),
  .brk_flags    (brk_flags),
  .brk_irq      (brk_irq)
);

// File: tb/brk_unit_tb.sv
module brk_unit_tb;
  localparam int AW = 32, DW = 32, TW = 4, NCH = 4, QW = 12;

  logic              clk;
  logic              rst_n;
  logic              bus_valid, bus_cpu, bus_fetch, bus_write;
  logic [AW-1:0]     bus_addr;
  logic [DW-1:0]     bus_data;
  logic [1:0]        bus_size;
  logic [TW-1:0]     bus_tag;
  logic              retire_valid;
  logic [TW-1:0]     retire_tag;
  logic [NCH*AW-1:0] cfg_addr, cfg_amask;
  logic [NCH*DW-1:0] cfg_data, cfg_dmask;
  logic [NCH*QW-1:0] cfg_qual;
  logic [NCH-1:0]    flag_clr;
  logic              brk_hold;
  logic [NCH-1:0]    brk_flags;
  logic              brk_irq;

  int total = 0;
  int bad   = 0;

  brk_unit u_dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // qualifier fields: {den, post, size, szchk, dir, acc, master, en}
  function automatic logic [11:0] q(input logic en, input logic [1:0] m, input logic [1:0] a,
                                    input logic [1:0] d, input logic sc, input logic [1:0] sz,
                                    input logic post, input logic den);
    q = {den, post, sz, sc, d, a, m, en};
  endfunction

  typedef struct packed {
    logic [1:0]  ch;
    logic [31:0] addr;
    logic [31:0] amask;
    logic [31:0] data;
    logic [31:0] dmask;
    logic [11:0] qual;
    logic [31:0] baddr;
    logic [31:0] bdata;
    logic        cpu;
    logic        fetch;
    logic        wr;
    logic [1:0]  size;
    logic        exp;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'h404,  32'h0,  32'h0, 32'h0, q(1,2'b01,2'b01,2'b01,0,2'd0,0,0), 32'h404,  32'h0, 1,1,0,2'd2, 1}, // R2 R6
    '{2'd0, 32'h404,  32'h0,  32'h0, 32'h0, q(1,2'b01,2'b01,2'b01,0,2'd0,0,0), 32'h408,  32'h0, 1,1,0,2'd2, 0}, // R2
    '{2'd1, 32'h3080, 32'h7F, 32'h0, 32'h0, q(1,2'b01,2'b01,2'b01,0,2'd0,0,0), 32'h30FF, 32'h0, 1,1,0,2'd2, 1}, // R2
    '{2'd1, 32'h3080, 32'h7F, 32'h0, 32'h0, q(1,2'b01,2'b01,2'b01,0,2'd0,0,0), 32'h3100, 32'h0, 1,1,0,2'd2, 0}, // R2
    '{2'd2, 32'h8010, 32'h6,  32'h0, 32'h0, q(1,2'b01,2'b01,2'b01,0,2'd0,0,0), 32'h8016, 32'h0, 1,1,0,2'd2, 1}, // R2
    '{2'd2, 32'h8010, 32'h6,  32'h0, 32'h0, q(1,2'b01,2'b01,2'b01,0,2'd0,0,0), 32'h8011, 32'h0, 1,1,0,2'd2, 0}, // R2
    '{2'd2, 32'h500, 32'h0, 32'h12340000, 32'h0000FFFF, q(1,2'b00,2'b10,2'b00,0,2'd0,0,1), 32'h500, 32'h1234ABCD, 1,0,0,2'd2, 1}, // R3
    '{2'd2, 32'h500, 32'h0, 32'h12340000, 32'h0000FFFF, q(1,2'b00,2'b10,2'b00,0,2'd0,0,1), 32'h500, 32'h12350000, 1,0,0,2'd2, 0}, // R3
    '{2'd2, 32'h500, 32'h0, 32'h12340000, 32'h0000FFFF, q(1,2'b00,2'b10,2'b00,0,2'd0,0,0), 32'h500, 32'h99999999, 1,0,0,2'd2, 1}, // R3
    '{2'd0, 32'h500, 32'h0, 32'h12340000, 32'h0,        q(1,2'b00,2'b10,2'b00,0,2'd0,0,1), 32'h500, 32'h99999999, 1,0,0,2'd2, 1}, // R3
    '{2'd3, 32'h600, 32'h0, 32'h0, 32'h0, q(1,2'b10,2'b00,2'b00,0,2'd0,0,0), 32'h600, 32'h0, 1,0,0,2'd2, 0}, // R4
    '{2'd3, 32'h600, 32'h0, 32'h0, 32'h0, q(1,2'b00,2'b00,2'b10,0,2'd0,0,0), 32'h600, 32'h0, 0,0,1,2'd2, 1}, // R4
    '{2'd3, 32'h600, 32'h0, 32'h0, 32'h0, q(1,2'b00,2'b00,2'b10,0,2'd0,0,0), 32'h600, 32'h0, 0,0,0,2'd2, 0}, // R4
    '{2'd0, 32'h700, 32'h0, 32'h0, 32'h0, q(1,2'b00,2'b10,2'b00,1,2'd2,0,0), 32'h700, 32'h0, 1,0,0,2'd2, 1}, // R5
    '{2'd0, 32'h700, 32'h0, 32'h0, 32'h0, q(1,2'b00,2'b10,2'b00,1,2'd2,0,0), 32'h700, 32'h0, 1,0,0,2'd1, 0}, // R5
    '{2'd0, 32'h700, 32'h0, 32'h0, 32'h0, q(1,2'b00,2'b10,2'b00,0,2'd2,0,0), 32'h700, 32'h0, 1,0,0,2'd1, 1}, // R5
    '{2'd1, 32'h700, 32'h0, 32'h0, 32'h0, q(0,2'b00,2'b00,2'b00,0,2'd0,0,0), 32'h700, 32'h0, 1,0,0,2'd2, 0}, // R11
    '{2'd0, 32'h800, 32'h0, 32'h0, 32'h0, q(1,2'b00,2'b01,2'b00,0,2'd0,0,0), 32'h800, 32'h0, 1,0,0,2'd2, 0}, // R4
    '{2'd3, 32'h900, 32'h0, 32'h0, 32'h0, q(1,2'b00,2'b10,2'b00,0,2'd0,1,0), 32'h900, 32'h0, 1,0,1,2'd2, 1}  // R8
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_bus();
    bus_valid = 0; bus_addr = '0; bus_data = '0; bus_cpu = 1; bus_fetch = 0;
    bus_write = 0; bus_size = 2'd2; bus_tag = '0; retire_valid = 0; retire_tag = '0;
    flag_clr = '0;
  endtask

  task automatic clear_cfg();
    cfg_addr = '0; cfg_amask = '0; cfg_data = '0; cfg_dmask = '0; cfg_qual = '0;
  endtask

  task automatic set_ch(input int c, input logic [31:0] a, input logic [31:0] am,
                        input logic [31:0] d, input logic [31:0] dm, input logic [11:0] qv);
    cfg_addr[c*AW +: AW] = a;  cfg_amask[c*AW +: AW] = am;
    cfg_data[c*DW +: DW] = d;  cfg_dmask[c*DW +: DW] = dm;
    cfg_qual[c*QW +: QW] = qv;
  endtask

  task automatic fetch(input logic [31:0] a, input logic [TW-1:0] t);
    bus_valid = 1; bus_addr = a; bus_fetch = 1; bus_cpu = 1; bus_write = 0; bus_tag = t;
  endtask

  task automatic clear_all();
    @(negedge clk); idle_bus(); flag_clr = '1;
    @(negedge clk); flag_clr = '0;
  endtask

  initial begin : watchdog
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle_bus(); clear_cfg();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 flags in reset", brk_flags, 0);
    chk("R1 irq in reset", brk_irq, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 flags after reset", brk_flags, 0);
    chk("R1 hold after reset", brk_hold, 0);

    for (int v = 0; v < NV; v++) begin
      clear_all();
      clear_cfg();
      set_ch(VECS[v].ch, VECS[v].addr, VECS[v].amask, VECS[v].data, VECS[v].dmask, VECS[v].qual);
      bus_valid = 1; bus_addr = VECS[v].baddr; bus_data = VECS[v].bdata;
      bus_cpu = VECS[v].cpu; bus_fetch = VECS[v].fetch; bus_write = VECS[v].wr;
      bus_size = VECS[v].size;
      #1;
      chk($sformatf("R6 hold vec %0d", v), brk_hold,
          VECS[v].exp && VECS[v].fetch && !VECS[v].qual[10]);
      @(negedge clk); idle_bus();
      chk($sformatf("R2-table vec %0d flags", v), brk_flags, VECS[v].exp ? (1 << VECS[v].ch) : 0);
      chk($sformatf("R10 vec %0d irq", v), brk_irq, VECS[v].exp);
    end

    // R7 post-execution timing
    clear_all(); clear_cfg();
    set_ch(0, 32'h404, 0, 0, 0, q(1,2'b01,2'b01,2'b01,0,2'd0,1,0));
    fetch(32'h404, 4'd5);
    #1 chk("R7 no hold", brk_hold, 0);
    @(negedge clk); idle_bus();
    chk("R7 no flag at fetch", brk_flags, 0);
    retire_valid = 1; retire_tag = 4'd6;
    @(negedge clk); idle_bus();
    chk("R7 wrong tag ignored", brk_flags, 0);
    retire_valid = 1; retire_tag = 4'd5;
    @(negedge clk); idle_bus();
    chk("R7 flag on retire", brk_flags, 4'b0001);

    // R12 newest pending tag replaces older
    clear_all(); clear_cfg();
    set_ch(1, 32'hA00, 32'hF, 0, 0, q(1,2'b00,2'b01,2'b00,0,2'd0,1,0));
    fetch(32'hA00, 4'd1);
    @(negedge clk); fetch(32'hA04, 4'd2);
    @(negedge clk); idle_bus(); retire_valid = 1; retire_tag = 4'd1;
    @(negedge clk); idle_bus();
    chk("R12 old tag dropped", brk_flags, 0);
    retire_valid = 1; retire_tag = 4'd2;
    @(negedge clk); idle_bus();
    chk("R12 newest tag flags", brk_flags, 4'b0010);

    // R9 sticky and clear behaviour
    repeat (3) @(negedge clk);
    chk("R9 sticky", brk_flags, 4'b0010);
    flag_clr = 4'b0001;
    @(negedge clk); idle_bus();
    chk("R9 other clear no effect", brk_flags, 4'b0010);
    flag_clr = 4'b0010;
    @(negedge clk); idle_bus();
    chk("R9 own clear", brk_flags, 0);
    clear_cfg();
    set_ch(2, 32'hB00, 0, 0, 0, q(1,2'b00,2'b00,2'b00,0,2'd0,0,0));
    bus_valid = 1; bus_addr = 32'hB00;
    @(negedge clk); idle_bus();
    chk("R9 set flag", brk_flags, 4'b0100);
    bus_valid = 1; bus_addr = 32'hB00; flag_clr = 4'b0100;
    @(negedge clk); idle_bus();
    chk("R9 set wins over clear", brk_flags, 4'b0100);

    // R11 independent channels, R10 irq
    clear_all(); clear_cfg();
    set_ch(0, 32'hC00, 0, 0, 0, q(1,2'b00,2'b00,2'b00,0,2'd0,0,0));
    set_ch(3, 32'hC00, 32'hFF, 0, 0, q(1,2'b00,2'b00,2'b00,0,2'd0,0,0));
    bus_valid = 1; bus_addr = 32'hC00;
    @(negedge clk); idle_bus();
    chk("R11 two channels", brk_flags, 4'b1001);
    flag_clr = 4'b0001;
    @(negedge clk); idle_bus();
    chk("R10 irq with one flag", brk_irq, 1);
    flag_clr = 4'b1000;
    @(negedge clk); idle_bus();
    chk("R10 irq low", brk_irq, 0);

    // R1 mid-run reset
    bus_valid = 1; bus_addr = 32'hC00;
    @(negedge clk); idle_bus();
    rst_n = 0;
    #1 chk("R1 async reset clears", brk_flags, 0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 irq after reset", brk_irq, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule